// File: doc/BRIEF.md
# Invalidatable Translation Lookaside Buffer

A small, fully associative translation cache that holds recent virtual-to-physical page translations. Each entry pairs a 20-bit virtual page number with a 20-bit physical page number and two permission flags (read allowed, write allowed). A client presents a virtual page number. One cycle later the buffer reports whether it holds a translation and, on a hit, returns the cached physical page and permissions. On a miss, the page walker supplies the translation through the refill port, and the buffer places it in a slot chosen by a round-robin pointer.

Software keeps the buffer coherent with the page tables in two ways. It can write a full virtual address to the single-page invalidate port, which removes any entry for that 4 KiB page. It can also issue a command: the flush code empties the whole buffer. Acknowledging a serviced page fault flushes the buffer as well, so no stale translation survives the fault handling.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_valid` and `lk_hit` are low, and any lookup misses.
- R2: `lk_valid` is high in exactly the cycle after a cycle with `lk_req` high. `lk_hit` is low whenever `lk_valid` is low.
- R3: On a hit, `lk_ppn`, `lk_rd` and `lk_wr` equal the physical page and permissions of the entry whose virtual page matches `lk_vpn`.
- R4: A refill of a page that is not present writes the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping after the last slot, so the ninth new page evicts the first of eight.
- R5: An `inv_en` pulse removes the entry whose page equals `inv_addr` bits 31:12. The offset bits 11:0 are ignored, and other entries are untouched.
- R6: A command with `cmd_code` 4 invalidates every entry.
- R7: A command with `cmd_code` 5 (page-fault acknowledge) also invalidates every entry.
- R8: Commands with any other code leave every entry unchanged.
- R9: If a refill and an invalidate name the same page in the same cycle, the invalidate wins: that page is absent afterwards and the pointer does not move. A flush in the same cycle as a refill likewise discards the refill.
- R10: A refill of a page that is already present overwrites that entry in place and does not advance the pointer, so a page never occupies two entries.
- R11: A lookup is evaluated against the contents before any refill, invalidate or flush in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| lk_valid | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_ppn | output | 20 | Physical page number of the hit entry |
| lk_rd | output | 1 | Read permission of the hit entry |
| lk_wr | output | 1 | Write permission of the hit entry |
| fill_en | input | 1 | Refill strobe from the page walker |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_ppn | input | 20 | Physical page number of the refill |
| fill_rd | input | 1 | Read permission of the refill |
| fill_wr | input | 1 | Write permission of the refill |
| inv_en | input | 1 | Single-page invalidate strobe |
| inv_addr | input | 32 | Virtual address whose page is invalidated |
| cmd_en | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (4 flush, 5 fault acknowledge) |

## Verification
A corrupted valid bit, tag or round-robin pointer shows up at the ports on the very next lookup of the affected page, one cycle after the request. It appears as a hit where the bench's model expects a miss, as a miss after a refill, or as a wrong physical page or permission. Pointer faults appear only after enough new pages have been refilled to reach the displaced slot. For that reason the directed part fills the buffer past its capacity and mixes duplicate refills with new ones. The random part then draws from a small pool of pages, so hits, evictions and invalidations collide often.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   parameter int unsigned XLAT_PN_W = 20;
   parameter int unsigned XLAT_CMD_W = 3;

   typedef logic [XLAT_PN_W-1:0] pn_t;

   typedef struct packed {
      pn_t  vpn;
      pn_t  ppn;
      logic rd;
      logic wr;
   } xlat_ent_t;

   localparam logic [XLAT_CMD_W-1:0] CMD_FLUSH     = 3'd4;
   localparam logic [XLAT_CMD_W-1:0] CMD_FAULT_ACK = 3'd5;
endpackage

// File: rtl/xlat_match.sv
module xlat_match
   import xlat_pkg::*;
#(
   parameter int unsigned N = 8
) (
   input  xlat_ent_t [N-1:0] ents,
   input  logic [N-1:0]      valid,
   input  pn_t               key,
   output logic [N-1:0]      hit
);
   if (N < 2) begin : g_bad_n
      $error("xlat_match: N must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit[i] = valid[i] && (ents[i].vpn == key);
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [IW-1:0] ptr
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   p_ptr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
   p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
endmodule

// File: rtl/xlat_store.sv
module xlat_store
   import xlat_pkg::*;
#(
   parameter int unsigned N = 8,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [N-1:0]      kill,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  xlat_ent_t         wr_ent,
   output logic [N-1:0]      valid,
   output xlat_ent_t [N-1:0] ents
);
   // Priority per slot: flush clears, a write sets, a kill clears.
   for (genvar i = 0; i < N; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IW'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid[i] <= 1'b0;
            ents[i]  <= '0;
         end else begin
            if (sel) ents[i] <= wr_ent;
            if (flush)        valid[i] <= 1'b0;
            else if (sel)     valid[i] <= 1'b1;
            else if (kill[i]) valid[i] <= 1'b0;
         end
      end
   end

   p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush) |=> valid[$past(wr_idx)]);
   p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid == '0));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int unsigned ENTRIES   = 8,
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PAGE_BITS = 12,
   localparam int unsigned PN_W = VA_W - PAGE_BITS,
   localparam int unsigned IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lk_req,
   input  logic [PN_W-1:0]       lk_vpn,
   output logic                  lk_valid,
   output logic                  lk_hit,
   output logic [PN_W-1:0]       lk_ppn,
   output logic                  lk_rd,
   output logic                  lk_wr,
   input  logic                  fill_en,
   input  logic [PN_W-1:0]       fill_vpn,
   input  logic [PN_W-1:0]       fill_ppn,
   input  logic                  fill_rd,
   input  logic                  fill_wr,
   input  logic                  inv_en,
   input  logic [VA_W-1:0]       inv_addr,
   input  logic                  cmd_en,
   input  logic [XLAT_CMD_W-1:0] cmd_code
);
   if (PN_W != XLAT_PN_W) begin : g_bad_width
      $error("xlat_cache: VA_W - PAGE_BITS must equal XLAT_PN_W");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("xlat_cache: ENTRIES must be at least 2");
   end

   logic [ENTRIES-1:0]      valid;
   xlat_ent_t [ENTRIES-1:0] ents;
   logic [ENTRIES-1:0]      look_hit, fill_hit, inv_hit;
   logic [IW-1:0]           ptr, dup_idx, wr_idx;
   pn_t                     inv_vpn;
   logic                    flush_req, inv_same, fill_eff, fill_new;
   xlat_ent_t               sel_ent, new_ent;

   assign inv_vpn   = inv_addr[VA_W-1:PAGE_BITS];
   assign flush_req = cmd_en && (cmd_code == CMD_FLUSH || cmd_code == CMD_FAULT_ACK);
   assign inv_same  = inv_en && (inv_vpn == fill_vpn);
   assign fill_eff  = fill_en && !flush_req && !inv_same;
   assign fill_new  = fill_eff && (fill_hit == '0);

   // Three comparator banks share the same tag array.
   xlat_match #(.N(ENTRIES)) u_look (.ents(ents), .valid(valid), .key(lk_vpn),   .hit(look_hit));
   xlat_match #(.N(ENTRIES)) u_fill (.ents(ents), .valid(valid), .key(fill_vpn), .hit(fill_hit));
   xlat_match #(.N(ENTRIES)) u_inv  (.ents(ents), .valid(valid), .key(inv_vpn),  .hit(inv_hit));

   xlat_victim #(.N(ENTRIES)) u_victim (
      .clk(clk), .rst_n(rst_n), .adv(fill_new), .ptr(ptr)
   );

   always_comb begin
      dup_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (fill_hit[i]) dup_idx = IW'(i);
      end
   end
   assign wr_idx = (fill_hit != '0) ? dup_idx : ptr;

   always_comb begin
      new_ent.vpn = fill_vpn;
      new_ent.ppn = fill_ppn;
      new_ent.rd  = fill_rd;
      new_ent.wr  = fill_wr;
   end

   xlat_store #(.N(ENTRIES)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush_req),
      .kill(inv_en ? inv_hit : '0),
      .wr_en(fill_eff), .wr_idx(wr_idx), .wr_ent(new_ent),
      .valid(valid), .ents(ents)
   );

   // At most one slot matches, so OR-reducing the masked entries selects it.
   always_comb begin
      sel_ent = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         sel_ent = sel_ent | (look_hit[i] ? ents[i] : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_valid <= 1'b0;
         lk_hit   <= 1'b0;
         lk_ppn   <= '0;
         lk_rd    <= 1'b0;
         lk_wr    <= 1'b0;
      end else begin
         lk_valid <= lk_req;
         lk_hit   <= lk_req && (look_hit != '0);
         lk_ppn   <= sel_ent.ppn;
         lk_rd    <= sel_ent.rd;
         lk_wr    <= sel_ent.wr;
      end
   end

   p_req_to_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> (!lk_valid && !lk_hit));
   p_unique_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_hit) && $onehot0(fill_hit));
   // Covers R7 as well: both flush codes drive flush_req.
   p_flush_then_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flush_req) && lk_req) |=> !lk_hit);
   p_inv_beats_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fill_en && inv_same) && lk_req && lk_vpn == $past(fill_vpn)) |=> !lk_hit);
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_req = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic        lk_valid, lk_hit, lk_rd, lk_wr;
   logic [19:0] lk_ppn;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0, fill_ppn = '0;
   logic        fill_rd = 1'b0, fill_wr = 1'b0;
   logic        inv_en = 1'b0;
   logic [31:0] inv_addr = '0;
   logic        cmd_en = 1'b0;
   logic [2:0]  cmd_code = '0;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   logic        mvalid [8];
   logic [19:0] mvpn [8];
   logic [19:0] mppn [8];
   logic        mrd [8];
   logic        mwr [8];
   int          mptr;

   always #2 clk = ~clk;

   xlat_cache uut (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
      .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd(lk_rd), .lk_wr(lk_wr),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rd(fill_rd), .fill_wr(fill_wr), .inv_en(inv_en), .inv_addr(inv_addr),
      .cmd_en(cmd_en), .cmd_code(cmd_code)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int mfind(input logic [19:0] v);
      for (int i = 0; i < 8; i++) if (mvalid[i] && mvpn[i] == v) return i;
      return -1;
   endfunction

   function automatic logic [19:0] ppn_of(input logic [19:0] v);
      return v ^ 20'h5A3C7;
   endfunction

   task automatic mreset();
      for (int i = 0; i < 8; i++) begin
         mvalid[i] = 1'b0; mvpn[i] = '0; mppn[i] = '0; mrd[i] = 1'b0; mwr[i] = 1'b0;
      end
      mptr = 0;
   endtask

   // One clock: drive at the falling edge, check the registered result a cycle later.
   task automatic step(input logic rq, input logic [19:0] rv,
                       input logic fe, input logic [19:0] fv, input logic [19:0] fp, input logic [1:0] fperm,
                       input logic ie, input logic [31:0] ia,
                       input logic ce, input logic [2:0] cc, input string tag);
      int idx, wi;
      logic eh, fe_eff;
      logic [19:0] ep;
      logic er, ew;
      lk_req = rq; lk_vpn = rv;
      fill_en = fe; fill_vpn = fv; fill_ppn = fp; fill_rd = fperm[0]; fill_wr = fperm[1];
      inv_en = ie; inv_addr = ia; cmd_en = ce; cmd_code = cc;
      // R11: the lookup sees the contents before this cycle's updates.
      idx = mfind(rv);
      eh = rq && (idx >= 0);
      ep = (idx >= 0) ? mppn[idx] : '0;
      er = (idx >= 0) ? mrd[idx] : 1'b0;
      ew = (idx >= 0) ? mwr[idx] : 1'b0;
      if (ce && (cc == 3'd4 || cc == 3'd5)) begin
         for (int i = 0; i < 8; i++) mvalid[i] = 1'b0;
      end else begin
         fe_eff = fe && !(ie && ia[31:12] == fv);
         wi = -1;
         if (fe_eff) begin
            wi = mfind(fv);
            if (wi < 0) begin
               wi = mptr;
               mptr = (mptr + 1) % 8;
            end
         end
         if (ie) begin
            for (int i = 0; i < 8; i++)
               if (mvalid[i] && mvpn[i] == ia[31:12] && i != wi) mvalid[i] = 1'b0;
         end
         if (wi >= 0) begin
            mvalid[wi] = 1'b1; mvpn[wi] = fv; mppn[wi] = fp; mrd[wi] = fperm[0]; mwr[wi] = fperm[1];
         end
      end
      @(posedge clk);
      @(negedge clk);
      lk_req = 1'b0; fill_en = 1'b0; inv_en = 1'b0; cmd_en = 1'b0;
      chk(lk_valid == rq, "R2 lk_valid", 32'(lk_valid), 32'(rq));
      chk(lk_hit == eh, tag, 32'(lk_hit), 32'(eh));
      if (eh) begin
         chk(lk_ppn == ep, "R3 ppn", 32'(lk_ppn), 32'(ep));
         chk({lk_wr, lk_rd} == {ew, er}, "R3 perms", 32'({lk_wr, lk_rd}), 32'({ew, er}));
      end
   endtask

   task automatic look(input logic [19:0] v, input string tag);
      step(1'b1, v, 1'b0, '0, '0, 2'b00, 1'b0, '0, 1'b0, 3'd0, tag);
   endtask

   task automatic fill(input logic [19:0] v, input logic [1:0] perm);
      step(1'b0, '0, 1'b1, v, ppn_of(v), perm, 1'b0, '0, 1'b0, 3'd0, "R2 idle");
   endtask

   task automatic cmd(input logic [2:0] c);
      step(1'b0, '0, 1'b0, '0, '0, 2'b00, 1'b0, '0, 1'b1, c, "R2 idle");
   endtask

   localparam logic [19:0] BASE = 20'h40100;

   initial begin
      #(4 * 200000);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      mreset();
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports, then a lookup misses.
      chk(lk_valid == 1'b0, "R1 lk_valid", 32'(lk_valid), 32'd0);
      chk(lk_hit == 1'b0, "R1 lk_hit", 32'(lk_hit), 32'd0);
      look(BASE, "R1 miss after reset");

      // R4: fill all eight slots, each hits with its own data.
      for (int i = 0; i < 8; i++) fill(BASE + 20'(i), 2'(i));
      for (int i = 0; i < 8; i++) look(BASE + 20'(i), "R4 filled hit");
      // R4: the ninth new page evicts slot 0.
      fill(BASE + 20'd8, 2'b11);
      look(BASE, "R4 evicted miss");
      look(BASE + 20'd8, "R4 new hit");

      // R10: a duplicate refill updates in place; the next new page evicts slot 1.
      step(1'b0, '0, 1'b1, BASE + 20'd3, 20'hABCDE, 2'b10, 1'b0, '0, 1'b0, 3'd0, "R2 idle");
      look(BASE + 20'd3, "R10 in-place update");
      fill(BASE + 20'd9, 2'b01);
      look(BASE + 20'd1, "R10 pointer held");
      look(BASE + 20'd2, "R10 neighbour kept");

      // R5: invalidate by address with non-zero offset bits.
      step(1'b0, '0, 1'b0, '0, '0, 2'b00, 1'b1, {BASE + 20'd4, 12'hABC}, 1'b0, 3'd0, "R2 idle");
      look(BASE + 20'd4, "R5 removed");
      look(BASE + 20'd5, "R5 other kept");

      // R8: other command codes change nothing.
      cmd(3'd0); cmd(3'd1); cmd(3'd2); cmd(3'd3); cmd(3'd6); cmd(3'd7);
      for (int i = 2; i < 10; i++) look(BASE + 20'(i), "R8 no effect");

      // R6: flush code empties the buffer.
      cmd(3'd4);
      for (int i = 0; i < 10; i++) look(BASE + 20'(i), "R6 flushed");

      // R7: fault acknowledge also empties it.
      fill(BASE + 20'd20, 2'b11);
      fill(BASE + 20'd21, 2'b01);
      look(BASE + 20'd20, "R7 before ack");
      cmd(3'd5);
      look(BASE + 20'd20, "R7 after ack");
      look(BASE + 20'd21, "R7 after ack");

      // R9: invalidate and refill of the same page in one cycle.
      step(1'b0, '0, 1'b1, BASE + 20'd30, ppn_of(BASE + 20'd30), 2'b11,
           1'b1, {BASE + 20'd30, 12'h004}, 1'b0, 3'd0, "R2 idle");
      look(BASE + 20'd30, "R9 invalidate wins");
      step(1'b0, '0, 1'b1, BASE + 20'd31, ppn_of(BASE + 20'd31), 2'b11,
           1'b0, '0, 1'b1, 3'd4, "R2 idle");
      look(BASE + 20'd31, "R9 flush wins");

      // R11: a lookup in the refill cycle misses; the next one hits.
      step(1'b1, BASE + 20'd40, 1'b1, BASE + 20'd40, ppn_of(BASE + 20'd40), 2'b01,
           1'b0, '0, 1'b0, 3'd0, "R11 same-cycle lookup");
      look(BASE + 20'd40, "R11 following lookup");

      // Random mix over a small page pool.
      for (int n = 0; n < 4000; n++) begin
         logic [19:0] rv, fv, iv;
         logic rq, fe, ie, ce;
         rv = BASE + 20'($urandom_range(0, 11));
         fv = BASE + 20'($urandom_range(0, 11));
         iv = BASE + 20'($urandom_range(0, 11));
         rq = ($urandom_range(0, 9) < 7);
         fe = ($urandom_range(0, 9) < 3);
         ie = ($urandom_range(0, 9) < 1);
         ce = ($urandom_range(0, 49) < 2);
         step(rq, rv, fe, fv, 20'($urandom), 2'($urandom), ie, {iv, 12'($urandom)},
              ce, 3'($urandom_range(0, 7)), "R3 random hit");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule